// File: doc/BRIEF.md
# Routed Periodic Local Timer

A free-running down counter that produces a periodic interrupt for a cluster of cores. Software loads a 28-bit period, measured in reference ticks. The counter then counts down once per tick-enable pulse and reloads itself on every expiry. On each expiry it raises a sticky pending flag, which stays set until software acknowledges it.

The pending flag goes to exactly one destination: the IRQ or FIQ source vector of one of the cores. A 3-bit route field picks the destination. The flag appears as bit 11 of the 12-bit source vector for that core and line. Software uses a single-cycle 32-bit register port with three registers: route, control/status, and acknowledge. Reads are combinational from the address.

Top module: `periodic_route_timer`

## Requirements
- R1: After reset, the route, control and acknowledge registers read zero. The timer is stopped, the flag is clear, and every source vector bit is zero.
- R2: A write to offset 0x24 keeps only wdata[2:0]. A read of offset 0x24 returns those 3 bits in [2:0] and zero above them.
- R3: A write to offset 0x34 stores wdata[27:0] as the period. A read of offset 0x34 returns the period in [27:0], the running state in both bit 28 and bit 29, zero in bit 30, and the pending flag in bit 31.
- R4: A write to offset 0x34 with bit 29 set starts a full period from the new value P. The flag rises in the cycle after the P-th tick pulse, and the timer reloads and expires again every P ticks.
- R5: A period of zero never expires.
- R6: The flag stays set until it is cleared by an acknowledge or a stop. Further expiries while it is set change nothing.
- R7: In a write to offset 0x38, bit 31 clears the flag and bit 30 restarts a full period. The two act independently and may be set in the same write. A read of offset 0x38 returns zero.
- R8: If an acknowledge clear and an expiry fall in the same cycle, the flag stays set.
- R9: A write to offset 0x34 with bit 29 clear stops the timer and clears the flag. No expiry follows until the timer is started again.
- R10: While the flag is set, bit 11 of core route[1:0]'s vector is 1. That vector is the FIQ vector when route[2]=1 and the IRQ vector when route[2]=0. Core c occupies bits [12c+11:12c] of each output. Every other output bit is 0.
- R11: A route write while the flag is pending moves the asserted bit to the new destination from the next cycle, and the flag stays set.
- R12: A control write in a cycle with a tick pulse takes precedence: that tick is neither counted nor able to cause an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per reference tick |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_src_o | output | 48 | IRQ source vectors, 12 bits per core |
| fiq_src_o | output | 48 | FIQ source vectors, 12 bits per core |

## Verification
Read data depends only on the current address and the registered state, so the bench checks it in the same cycle, one time step after it drives the address. A write, tick or acknowledge takes effect on the next rising edge. The source vectors and the readable state change one cycle after that stimulus, so every stimulus cycle ends with a check just after that edge. In that check, the bench compares both source vectors against a cycle model that it updates with the inputs it drove. Directed sequences count tick pulses exactly around each expiry, and they line up an acknowledge, a route change or a control write with an expiring tick.

// File: rtl/prt_pkg.sv
package prt_pkg;
  localparam logic [7:0] OFF_ROUTE = 8'h24;
  localparam logic [7:0] OFF_CTRL  = 8'h34;
  localparam logic [7:0] OFF_ACK   = 8'h38;

  localparam int CTL_TEN  = 28;
  localparam int CTL_IEN  = 29;
  localparam int CTL_FLAG = 31;
  localparam int ACK_CLR  = 31;
  localparam int ACK_RST  = 30;

  typedef enum logic [1:0] {SEL_NONE, SEL_ROUTE, SEL_CTRL, SEL_ACK} reg_sel_e;
endpackage

// File: rtl/prt_regs.sv
module prt_regs
  import prt_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 28,
  parameter int ROUTE_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  input  logic               flag_i,
  input  logic               run_i,
  output logic [ROUTE_W-1:0] route_o,
  output logic [CNT_W-1:0]   reload_o,
  output logic               ctrl_wr_o,
  output logic               ack_wr_o,
  output logic [31:0]        rdata_o
);
  reg_sel_e sel;

  always_comb begin
    if (addr_i == ADDR_W'(OFF_ROUTE))     sel = SEL_ROUTE;
    else if (addr_i == ADDR_W'(OFF_CTRL)) sel = SEL_CTRL;
    else if (addr_i == ADDR_W'(OFF_ACK))  sel = SEL_ACK;
    else                                  sel = SEL_NONE;
  end

  assign ctrl_wr_o = we_i && (sel == SEL_CTRL);
  assign ack_wr_o  = we_i && (sel == SEL_ACK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_o  <= '0;
      reload_o <= '0;
    end else begin
      if (we_i && sel == SEL_ROUTE) route_o <= wdata_i[ROUTE_W-1:0];
      if (ctrl_wr_o)                reload_o <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_ROUTE: rdata_o[ROUTE_W-1:0] = route_o;
      SEL_CTRL: begin
        rdata_o[CNT_W-1:0] = reload_o;
        rdata_o[CTL_TEN]   = run_i;
        rdata_o[CTL_IEN]   = run_i;
        rdata_o[CTL_FLAG]  = flag_i;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/prt_counter.sv
module prt_counter #(
  parameter int CNT_W = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             restart_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             flag_o,
  output logic             run_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_one;
  logic             expire;

  assign at_one = (cnt_q == CNT_W'(1));
  // control writes own the cycle; the tick is dropped
  assign expire = run_o && tick_i && at_one && !(start_i || stop_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_o  <= 1'b0;
      flag_o <= 1'b0;
    end else if (stop_i) begin
      cnt_q  <= '0;
      run_o  <= 1'b0;
      flag_o <= 1'b0;
    end else if (start_i) begin
      cnt_q <= load_val_i;
      run_o <= 1'b1;
    end else begin
      if (restart_i)
        cnt_q <= load_val_i;
      else if (run_o && tick_i && cnt_q != '0)
        cnt_q <= at_one ? load_val_i : cnt_q - CNT_W'(1);
      // expiry beats a same-cycle clear
      if (expire)     flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/prt_router.sv
module prt_router #(
  parameter int NCORES  = 4,
  parameter int SRC_W   = 12,
  parameter int SRC_BIT = 11,
  parameter int ROUTE_W = 3
) (
  input  logic                    flag_i,
  input  logic [ROUTE_W-1:0]      route_i,
  output logic [NCORES*SRC_W-1:0] irq_src_o,
  output logic [NCORES*SRC_W-1:0] fiq_src_o
);
  localparam int CORE_W = ROUTE_W - 1;

  logic             to_fiq;
  logic [CORE_W-1:0] core_sel;

  assign to_fiq   = route_i[CORE_W];
  assign core_sel = route_i[CORE_W-1:0];

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    logic hit;
    assign hit = flag_i && (core_sel == CORE_W'(c));
    for (genvar b = 0; b < SRC_W; b++) begin : g_bit
      if (b == SRC_BIT) begin : g_live
        assign irq_src_o[c*SRC_W+b] = hit && !to_fiq;
        assign fiq_src_o[c*SRC_W+b] = hit && to_fiq;
      end else begin : g_zero
        assign irq_src_o[c*SRC_W+b] = 1'b0;
        assign fiq_src_o[c*SRC_W+b] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/periodic_route_timer.sv
module periodic_route_timer
  import prt_pkg::*;
#(
  parameter int NCORES  = 4,
  parameter int SRC_W   = 12,
  parameter int SRC_BIT = 11,
  parameter int CNT_W   = 28,
  parameter int ADDR_W  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  output logic [NCORES*SRC_W-1:0] irq_src_o,
  output logic [NCORES*SRC_W-1:0] fiq_src_o
);
  localparam int ROUTE_W = $clog2(NCORES) + 1;

  logic [ROUTE_W-1:0] route_w;
  logic [CNT_W-1:0]   reload_w;
  logic [CNT_W-1:0]   load_val_w;
  logic               ctrl_wr_w, ack_wr_w;
  logic               flag_w, run_w;

  prt_regs #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .ROUTE_W(ROUTE_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .flag_i   (flag_w),
    .run_i    (run_w),
    .route_o  (route_w),
    .reload_o (reload_w),
    .ctrl_wr_o(ctrl_wr_w),
    .ack_wr_o (ack_wr_w),
    .rdata_o  (rdata_o)
  );

  assign load_val_w = ctrl_wr_w ? wdata_i[CNT_W-1:0] : reload_w;

  prt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .start_i   (ctrl_wr_w && wdata_i[CTL_IEN]),
    .stop_i    (ctrl_wr_w && !wdata_i[CTL_IEN]),
    .restart_i (ack_wr_w && wdata_i[ACK_RST]),
    .clr_i     (ack_wr_w && wdata_i[ACK_CLR]),
    .load_val_i(load_val_w),
    .flag_o    (flag_w),
    .run_o     (run_w)
  );

  prt_router #(
    .NCORES (NCORES),
    .SRC_W  (SRC_W),
    .SRC_BIT(SRC_BIT),
    .ROUTE_W(ROUTE_W)
  ) u_router (
    .flag_i   (flag_w),
    .route_i  (route_w),
    .irq_src_o(irq_src_o),
    .fiq_src_o(fiq_src_o)
  );
endmodule

// File: rtl/prt_checker.sv
module prt_checker
  import prt_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int SRC_W  = 12,
  parameter int ADDR_W = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    tick_i,
  input logic                    we_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [31:0]             wdata_i,
  input logic [31:0]             rdata_o,
  input logic [NCORES*SRC_W-1:0] irq_src_o,
  input logic [NCORES*SRC_W-1:0] fiq_src_o,
  input logic                    flag,
  input logic                    run
);
  logic ack_wr, ctrl_wr;
  assign ack_wr  = we_i && addr_i == ADDR_W'(OFF_ACK);
  assign ctrl_wr = we_i && addr_i == ADDR_W'(OFF_CTRL);

  AST_ROUTE_READ_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == ADDR_W'(OFF_ROUTE) |-> rdata_o[31:3] == '0);  // R2

  AST_ACK_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == ADDR_W'(OFF_ACK) |-> rdata_o == '0);  // R7

  AST_ACK_CLEARS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_wr && wdata_i[ACK_CLR] && !tick_i |=> !flag);  // R7

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag && !ack_wr && !ctrl_wr |=> flag);  // R6

  AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && !wdata_i[CTL_IEN] |=> !flag && !run);  // R9

  AST_ONE_DEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({irq_src_o, fiq_src_o}) == 32'(flag));  // R10

  AST_RISE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !$rose(flag));  // R4
endmodule

bind periodic_route_timer prt_checker #(
  .NCORES(NCORES),
  .SRC_W (SRC_W),
  .ADDR_W(ADDR_W)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .irq_src_o(irq_src_o),
  .fiq_src_o(fiq_src_o),
  .flag     (flag_w),
  .run      (run_w)
);

// File: tb/periodic_route_timer_tb_top.sv
module periodic_route_timer_tb_top;
  localparam int NC = 4;
  localparam int SW = 12;
  localparam logic [7:0] A_RT = 8'h24, A_CT = 8'h34, A_AK = 8'h38;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NC*SW-1:0] irq, fiq;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [2:0]  m_route = '0;
  logic [27:0] m_reload = '0, m_cnt = '0;
  logic        m_run = 1'b0, m_flag = 1'b0;

  always #4 clk = ~clk;

  periodic_route_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_src_o(irq), .fiq_src_o(fiq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NC*SW-1:0] exp_vec(input logic want_fiq);
    logic [NC*SW-1:0] v = '0;
    if (m_flag && m_route[2] == want_fiq) v[m_route[1:0]*SW + 11] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a == A_RT) return {29'b0, m_route};
    if (a == A_CT) return {m_flag, 1'b0, m_run, m_run, m_reload};
    return 32'b0;
  endfunction

  task automatic model_step(input logic t, input logic w, input logic [7:0] a, input logic [31:0] d);
    logic ex;
    if (w && a == A_RT) m_route = d[2:0];
    if (w && a == A_CT) begin
      m_reload = d[27:0];
      if (d[29]) begin m_run = 1'b1; m_cnt = d[27:0]; end
      else begin m_run = 1'b0; m_flag = 1'b0; m_cnt = '0; end
    end else begin
      ex = m_run && t && m_cnt == 28'd1;
      if (w && a == A_AK && d[30]) m_cnt = m_reload;
      else if (m_run && t && m_cnt != 0) m_cnt = (m_cnt == 28'd1) ? m_reload : m_cnt - 28'd1;
      if (ex) m_flag = 1'b1;
      else if (w && a == A_AK && d[31]) m_flag = 1'b0;
    end
  endtask

  task automatic cyc(input logic t, input logic w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    tick = t; we = w; addr = a; wdata = d;
    @(posedge clk);
    model_step(t, w, a, d);
    #1;
    chk("R10 irq vectors", 64'(irq), 64'(exp_vec(1'b0)));
    chk("R10 fiq vectors", 64'(fiq), 64'(exp_vec(1'b1)));
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    tick = 1'b0; we = 1'b0; addr = a; wdata = '0;
    #1;
    chk(tag, 64'(rdata), 64'(exp));
    @(posedge clk);
    model_step(1'b0, 1'b0, a, 32'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 8'h00, 32'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [7:0] a;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    rd("R1 route after reset", A_RT, 32'h0);
    rd("R1 ctrl after reset", A_CT, 32'h0);
    rd("R1 ack after reset", A_AK, 32'h0);
    chk("R1 outputs idle", 64'(irq | fiq), 64'h0);
    // R2 route masking
    cyc(1'b0, 1'b1, A_RT, 32'hFFFF_FFFD);
    rd("R2 route keeps 3 bits", A_RT, 32'h5);
    cyc(1'b0, 1'b1, A_RT, 32'h0);
    // R3 R4 start, period 3
    cyc(1'b0, 1'b1, A_CT, 32'h2000_0003);
    rd("R3 ctrl running", A_CT, 32'h3000_0003);
    ticks(2);
    chk("R4 no flag before 3rd tick", 64'(irq[11]), 64'h0);
    ticks(1);
    chk("R4 flag after 3rd tick", 64'(irq[11]), 64'h1);
    rd("R3 ctrl with flag", A_CT, 32'hB000_0003);
    ticks(6);
    chk("R6 flag sticky over expiries", 64'(irq[11]), 64'h1);
    // R7 clear and read zero
    cyc(1'b0, 1'b1, A_AK, 32'h8000_0000);
    chk("R7 ack clears flag", 64'(irq[11]), 64'h0);
    rd("R7 ack reads zero", A_AK, 32'h0);
    // R8 clear coincides with expiry
    cyc(1'b0, 1'b1, A_AK, 32'h4000_0000);
    ticks(3);
    chk("R4 reload period", 64'(irq[11]), 64'h1);
    ticks(2);
    cyc(1'b1, 1'b1, A_AK, 32'h8000_0000);
    chk("R8 expiry beats clear", 64'(irq[11]), 64'h1);
    // R7 both bits
    ticks(1);
    cyc(1'b0, 1'b1, A_AK, 32'hC000_0000);
    chk("R7 both bits clear", 64'(irq[11]), 64'h0);
    ticks(2);
    chk("R7 restart full period", 64'(irq[11]), 64'h0);
    ticks(1);
    chk("R7 expiry after restart", 64'(irq[11]), 64'h1);
    // R11 route move while pending
    cyc(1'b0, 1'b1, A_RT, 32'h6);
    chk("R11 moved to core2 fiq", 64'(fiq), 64'(48'h1) << 35);
    chk("R11 irq cleared", 64'(irq), 64'h0);
    // R12 control write in tick cycle
    cyc(1'b0, 1'b1, A_AK, 32'h8000_0000);
    cyc(1'b1, 1'b1, A_CT, 32'h2000_0002);
    ticks(1);
    chk("R12 tick during write not counted", 64'(fiq[35]), 64'h0);
    ticks(1);
    chk("R12 expiry on 2nd tick", 64'(fiq[35]), 64'h1);
    // R5 zero period
    cyc(1'b0, 1'b1, A_CT, 32'h2000_0000);
    cyc(1'b0, 1'b1, A_AK, 32'h8000_0000);
    ticks(30);
    chk("R5 zero period never expires", 64'(fiq[35]), 64'h0);
    // R9 stop
    cyc(1'b0, 1'b1, A_CT, 32'h2000_0001);
    ticks(1);
    chk("R4 period 1 expires", 64'(fiq[35]), 64'h1);
    cyc(1'b0, 1'b1, A_CT, 32'h0000_0001);
    rd("R9 stopped ctrl", A_CT, 32'h0000_0001);
    ticks(5);
    chk("R9 no expiry when stopped", 64'(fiq | irq), 64'h0);
    // random mix
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 4000; i++) begin
      r = $urandom;
      case (r[3:0])
        4'd0: cyc(r[4], 1'b1, A_RT, $urandom);
        4'd1: cyc(r[4], 1'b1, A_CT, {2'b0, r[5], 1'b0, 25'b0, r[8:6]});
        4'd2, 4'd3: cyc(r[4], 1'b1, A_AK, {r[5], r[6], 30'b0});
        4'd4: begin
          a = (r[6:5] == 0) ? A_RT : (r[6:5] == 1) ? A_CT : A_AK;
          rd("R3 random read", a, model_read(a));
        end
        default: cyc(r[4], 1'b0, 8'h00, 32'b0);
      endcase
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule